// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

The block is the control engine of a small byte-wide processor. A 256-byte synchronous memory inside it holds both program and data. Each instruction is fetched one byte per cycle: an opcode, then for most instructions a byte giving the operand form, then one or two operand bytes. Operands can be a general register, a memory byte named by its address, or an immediate value. The sequencer reads any memory operands, then either moves the source value itself or hands both values to an external ALU. It writes the result back to a register or a memory byte.

The sequencer executes move, unconditional jump, jump on zero, jump on carry, no-operation and halt itself. The arithmetic, logic, shift and compare opcodes go through the ALU port, and the ALU answers in the same cycle. A loader port fills memory while reset is held. A store to one reserved address also drives an LED output register. The program counter and a halted flag are visible outside the block.

Top module: `instr_sequencer`

## Requirements
- R1: While reset is held and right after it is released, `pc` is 0, `halted` is 0 and `leds` is 0. Registers and flags clear to 0, and the first opcode is fetched from address 0.
- R2: Opcode 0x00, and any opcode from 0x0E to 0xFE, is one byte long. It takes 2 cycles, adds 1 to `pc` and changes no register, flag, memory byte or `leds`.
- R3: Opcode 0xFF raises `halted` 2 cycles after its fetch begins. `pc` then keeps the address of that byte until reset.
- R4: A two-operand instruction is laid out as opcode, type, operand A (the destination), operand B (the source). A register operand byte selects register R0 to R3 by its low 2 bits. The type codes are:
  - 0x00: A register, B register
  - 0x01: A register, B memory
  - 0x02: A memory, B register
  - 0x03: A register, B immediate
  - 0x05: A memory, B memory
  - 0x06: A memory, B immediate
- R5: A two-operand instruction takes 6 cycles and adds 4 to `pc`. It takes one more cycle when A is memory and the opcode is not move, one more when B is memory, and one more when A is memory (the write cycle).
- R6: Move (0x01) copies the source value to the destination and leaves the zero and carry flags unchanged.
- R7: ALU opcodes are 0x02 to 0x07 and 0x0B to 0x0D. For these, `alu_go` is high for exactly one cycle per instruction. In that cycle `alu_op` carries the opcode, `alu_a` the destination value and `alu_b` the source value. `alu_y` is written back, except for 0x0D, and `alu_zf`/`alu_cf` load the flags.
- R8: Jumps are 0x08 (always), 0x09 (if the zero flag is set) and 0x0A (if the carry flag is set). Each is three bytes long: opcode, type, operand. The target is a register for type 0x00, a memory byte at the operand address for type 0x01, and the operand itself for any other type. A jump takes 5 cycles, or 6 with type 0x01.
- R9: A conditional jump whose flag is clear sets `pc` to the address after its third byte.
- R10: A store to address 0xFF also loads `leds` at the end of the write cycle. Compare (0x0D) stores nothing.
- R11: With `ld_we` high, `ld_data` is written to memory at `ld_addr` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_we | input | 1 | Loader write enable |
| ld_addr | input | 8 | Loader address |
| ld_data | input | 8 | Loader data |
| alu_op | output | 8 | Opcode presented to the ALU |
| alu_a | output | 8 | Destination operand value |
| alu_b | output | 8 | Source operand value |
| alu_go | output | 1 | ALU operation issued this cycle |
| alu_y | input | 8 | ALU result, same cycle |
| alu_zf | input | 1 | ALU zero result |
| alu_cf | input | 1 | ALU carry or borrow |
| pc | output | 8 | Program counter |
| halted | output | 1 | Halt state reached |
| leds | output | 8 | LED output register |

## Verification
Every instruction finishes on a fixed clock edge. That edge is 2 cycles after fetch for one-byte opcodes, 5 or 6 for jumps, and 6 to 9 for two-operand forms depending on how many memory reads and writes they carry. A memory write to 0xFF shows on `leds` on the last of those edges. The bench runs a reference model one instruction at a time and derives each instruction's cycle count from R5 and R8. It then waits exactly that many falling edges before it compares `pc`, `leds` and `halted`, so a result that arrives one cycle early or late is caught. It also samples `alu_go` on every falling edge within the instruction to confirm a single issue cycle.

// File: rtl/instr_sequencer.sv
module instr_sequencer #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int NREG     = 4,
  parameter int LED_ADDR = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [7:0]    alu_op,
  output logic [DW-1:0] alu_a,
  output logic [DW-1:0] alu_b,
  output logic          alu_go,
  input  logic [DW-1:0] alu_y,
  input  logic          alu_zf,
  input  logic          alu_cf,
  output logic [AW-1:0] pc,
  output logic          halted,
  output logic [DW-1:0] leds
);
  localparam int DEPTH = 1 << AW;
  localparam int RSW   = $clog2(NREG);

  typedef enum logic [3:0] {S_F0, S_OP, S_TY, S_A, S_B, S_RA, S_RB, S_EX, S_WR, S_HLT} st_t;

  st_t           st;
  logic [7:0]    opc, typ;
  logic [DW-1:0] opa, opb, va, vb, res, rdata;
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] mem [DEPTH];
  logic          zf, cf;
  logic [AW-1:0] raddr;

  logic is_mov, is_jmp, is_alu, wb, dst_mem, src_mem, src_imm, rd_dst, j_mem, taken;
  logic [DW-1:0] a_val, b_val, tgt, res_c;

  assign is_mov  = opc == 8'h01;
  assign is_jmp  = opc == 8'h08 || opc == 8'h09 || opc == 8'h0A;
  assign is_alu  = (opc >= 8'h02 && opc <= 8'h07) || (opc >= 8'h0B && opc <= 8'h0D);
  assign wb      = opc != 8'h0D;
  assign dst_mem = typ == 8'h02 || typ == 8'h05 || typ == 8'h06;
  assign src_mem = typ == 8'h01 || typ == 8'h05;
  assign src_imm = typ == 8'h03 || typ == 8'h06;
  assign rd_dst  = dst_mem && !is_mov;
  assign j_mem   = typ == 8'h01;

  assign a_val = dst_mem ? va : rf[opa[RSW-1:0]];
  assign b_val = src_mem ? vb : (src_imm ? opb : rf[opb[RSW-1:0]]);
  assign tgt   = (typ == 8'h00) ? rf[opa[RSW-1:0]] : (j_mem ? va : opa);
  assign taken = opc == 8'h08 || (opc == 8'h09 && zf) || (opc == 8'h0A && cf);
  assign res_c = is_mov ? b_val : alu_y;

  assign alu_op = opc;
  assign alu_a  = a_val;
  assign alu_b  = b_val;
  assign alu_go = st == S_EX && is_alu;
  assign halted = st == S_HLT;

  always_comb begin
    case (st)
      S_OP:    raddr = pc + AW'(1);
      S_TY:    raddr = pc + AW'(2);
      S_A:     raddr = (is_jmp && j_mem) ? rdata[AW-1:0] : pc + AW'(3);
      S_B:     raddr = rd_dst ? opa[AW-1:0] : rdata[AW-1:0];
      S_RA:    raddr = opb[AW-1:0];
      default: raddr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ld_we)
      mem[ld_addr] <= ld_data;
    else if (st == S_WR && wb)
      mem[opa[AW-1:0]] <= res;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_F0;
      pc   <= '0;
      opc  <= '0;
      typ  <= '0;
      opa  <= '0;
      opb  <= '0;
      va   <= '0;
      vb   <= '0;
      res  <= '0;
      zf   <= 1'b0;
      cf   <= 1'b0;
      leds <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_F0: st <= S_OP;
        S_OP: begin
          opc <= rdata[7:0];
          if (rdata[7:0] == 8'hFF)
            st <= S_HLT;
          else if (rdata[7:0] >= 8'h01 && rdata[7:0] <= 8'h0D)
            st <= S_TY;
          else begin
            pc <= pc + AW'(1);
            st <= S_F0;
          end
        end
        S_TY: begin
          typ <= rdata[7:0];
          st  <= S_A;
        end
        S_A: begin
          opa <= rdata;
          if (!is_jmp)    st <= S_B;
          else if (j_mem) st <= S_RA;
          else            st <= S_EX;
        end
        S_B: begin
          opb <= rdata;
          st  <= rd_dst ? S_RA : (src_mem ? S_RB : S_EX);
        end
        S_RA: begin
          va <= rdata;
          st <= (!is_jmp && src_mem) ? S_RB : S_EX;
        end
        S_RB: begin
          vb <= rdata;
          st <= S_EX;
        end
        S_EX: begin
          if (is_jmp) begin
            pc <= taken ? tgt[AW-1:0] : pc + AW'(3);
            st <= S_F0;
          end else begin
            if (is_alu) begin
              zf <= alu_zf;
              cf <= alu_cf;
            end
            if (dst_mem) begin
              res <= res_c;
              st  <= S_WR;
            end else begin
              if (wb) rf[opa[RSW-1:0]] <= res_c;
              pc <= pc + AW'(4);
              st <= S_F0;
            end
          end
        end
        S_WR: begin
          if (wb && opa[AW-1:0] == AW'(LED_ADDR)) leds <= res;
          pc <= pc + AW'(4);
          st <= S_F0;
        end
        S_HLT: st <= S_HLT;
        default: st <= S_F0;
      endcase
    end
  end

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted && $stable(pc)); // R3
  AST_ALU_PULSE: assert property (@(posedge clk) disable iff (!rst_n) alu_go |=> !alu_go); // R7
  AST_LED_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(leds) |-> $past(st) == S_WR); // R10
  AST_MOV_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (st == S_EX && is_mov) |=> $stable(zf) && $stable(cf)); // R6
  AST_PC_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n) (st == S_TY || st == S_A || st == S_B || st == S_RA || st == S_RB) |=> $stable(pc)); // R5
endmodule

// File: tb/instr_sequencer_test.sv
module instr_sequencer_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ld_we = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;
  logic [7:0] alu_op, alu_a, alu_b, alu_y, pc, leds;
  logic       alu_go, alu_zf, alu_cf, halted;

  instr_sequencer uut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_go(alu_go),
    .alu_y(alu_y), .alu_zf(alu_zf), .alu_cf(alu_cf),
    .pc(pc), .halted(halted), .leds(leds)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] img [256];
  logic [7:0] rmem [256];
  logic [7:0] rreg [4];
  logic [7:0] rpc, rled;
  logic       rzf, rcf, rhalt;

  function automatic logic [9:0] alu_fn(logic [7:0] op, logic [7:0] a, logic [7:0] b);
    logic [8:0] t;
    logic [7:0] y;
    logic c;
    c = 1'b0;
    t = '0;
    case (op)
      8'h02: begin t = {1'b0, a} + {1'b0, b}; y = t[7:0]; c = t[8]; end
      8'h03, 8'h0D: begin t = {1'b0, a} - {1'b0, b}; y = t[7:0]; c = t[8]; end
      8'h04: y = a & b;
      8'h05: y = a | b;
      8'h06: y = a ^ b;
      8'h07: y = ~a;
      8'h0B: y = a << b[2:0];
      8'h0C: y = a >> b[2:0];
      default: y = 8'h00;
    endcase
    return {y == 8'h00, c, y};
  endfunction

  assign {alu_zf, alu_cf, alu_y} = alu_fn(alu_op, alu_a, alu_b);

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ref_step(output int cyc, output bit alu_i);
    logic [7:0] op, ty, ba, bb, a, b, r, tgt;
    logic [9:0] f;
    logic dm, sm, si, tk;
    alu_i = 0;
    op = rmem[rpc];
    if (op == 8'hFF) begin rhalt = 1; cyc = 2; return; end
    if (op == 8'h00 || op > 8'h0D) begin rpc = rpc + 8'd1; cyc = 2; return; end
    ty = rmem[rpc + 8'd1];
    ba = rmem[rpc + 8'd2];
    if (op >= 8'h08 && op <= 8'h0A) begin
      cyc = (ty == 8'h01) ? 6 : 5;
      tgt = (ty == 8'h00) ? rreg[ba[1:0]] : (ty == 8'h01) ? rmem[ba] : ba;
      tk = op == 8'h08 || (op == 8'h09 && rzf) || (op == 8'h0A && rcf);
      rpc = tk ? tgt : rpc + 8'd3;
      return;
    end
    bb = rmem[rpc + 8'd3];
    dm = ty == 8'h02 || ty == 8'h05 || ty == 8'h06;
    sm = ty == 8'h01 || ty == 8'h05;
    si = ty == 8'h03 || ty == 8'h06;
    a = dm ? rmem[ba] : rreg[ba[1:0]];
    b = sm ? rmem[bb] : (si ? bb : rreg[bb[1:0]]);
    cyc = 6 + int'(dm && op != 8'h01) + int'(sm) + int'(dm);
    if (op == 8'h01) r = b;
    else begin
      alu_i = 1;
      f = alu_fn(op, a, b);
      r = f[7:0]; rzf = f[9]; rcf = f[8];
    end
    if (op != 8'h0D) begin
      if (dm) begin
        rmem[ba] = r;
        if (ba == 8'hFF) rled = r;
      end else rreg[ba[1:0]] = r;
    end
    rpc = rpc + 8'd4;
  endtask

  task automatic run_prog();
    int cyc, steps, gos;
    bit alu_i;
    string tag;
    logic [7:0] op;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 8'(i); ld_data = img[i];
      rmem[i] = img[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    for (int i = 0; i < 4; i++) rreg[i] = '0;
    rpc = '0; rled = '0; rzf = 0; rcf = 0; rhalt = 0;
    chk("R1", "pc in reset", pc, 0);
    chk("R1", "halted in reset", halted, 0);
    chk("R1", "leds in reset", leds, 0);
    rst_n = 1'b1;
    steps = 0;
    while (!rhalt && steps < 300) begin
      op = rmem[rpc];
      if (op == 8'hFF) tag = "R3";
      else if (op == 8'h00 || op > 8'h0D) tag = "R2";
      else if (op >= 8'h08 && op <= 8'h0A) tag = "R8";
      else tag = "R5";
      ref_step(cyc, alu_i);
      gos = 0;
      repeat (cyc) begin
        @(negedge clk);
        if (alu_go) gos++;
      end
      chk(tag, "pc after instruction", pc, rpc);
      chk(tag, "halted after instruction", halted, rhalt);
      chk("R10", "leds after instruction", leds, rled);
      chk("R7", "alu_go cycles", 16'(gos), alu_i ? 16'd1 : 16'd0);
      steps++;
    end
    repeat (6) @(negedge clk);
    chk("R3", "halted holds", halted, 1);
    chk("R3", "pc frozen", pc, rpc);
  endtask

  task automatic gen_prog(int n);
    logic [7:0] op [20], ty [20], a [20], b [20], adr [21];
    int ln [20], k, j;
    logic [7:0] ops2 [10] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h0B, 8'h0C, 8'h0D};
    logic [7:0] tys [6] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h06};
    for (int i = 0; i < 256; i++) img[i] = (i >= 128) ? 8'($urandom) : 8'hFF;
    for (int i = 0; i < n; i++) begin
      k = int'($urandom % 10);
      if (k == 0) begin op[i] = 8'h00; ln[i] = 1; end
      else if (k == 1) begin op[i] = 8'($urandom_range(14, 254)); ln[i] = 1; end
      else if (k == 2) begin op[i] = 8'(8 + $urandom % 3); ty[i] = 8'h03; ln[i] = 3; end
      else if (k == 3) begin op[i] = 8'h01; ty[i] = 8'h02; a[i] = 8'hFF; b[i] = 8'($urandom); ln[i] = 4; end
      else begin
        op[i] = ops2[$urandom % 10];
        ty[i] = tys[$urandom % 6];
        ln[i] = 4;
        a[i] = (ty[i] == 8'h02 || ty[i] == 8'h05 || ty[i] == 8'h06) ? 8'(128 + $urandom % 128) : 8'($urandom);
        b[i] = (ty[i] == 8'h01 || ty[i] == 8'h05) ? 8'(128 + $urandom % 128) : 8'($urandom);
      end
    end
    adr[0] = 8'h00;
    for (int i = 0; i < n; i++) adr[i+1] = adr[i] + 8'(ln[i]);
    for (int i = 0; i < n; i++) begin
      img[adr[i]] = op[i];
      if (ln[i] == 3) begin
        j = i + 1 + int'($urandom % 3);
        if (j > n) j = n;
        img[adr[i] + 8'd1] = ty[i];
        img[adr[i] + 8'd2] = adr[j];
      end else if (ln[i] == 4) begin
        img[adr[i] + 8'd1] = ty[i];
        img[adr[i] + 8'd2] = a[i];
        img[adr[i] + 8'd3] = b[i];
      end
    end
    img[adr[n]] = 8'hFF;
  endtask

  task automatic put(logic [7:0] at, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    img[at] = b0; img[at + 8'd1] = b1; img[at + 8'd2] = b2; img[at + 8'd3] = b3;
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R2 R4 R10 R11: one-byte opcodes, register byte with upper bits set, LED store
    for (int i = 0; i < 256; i++) img[i] = 8'hFF;
    img[0] = 8'h00; img[1] = 8'h42;
    put(8'h02, 8'h01, 8'h03, 8'hF1, 8'h37);
    put(8'h06, 8'h01, 8'h02, 8'hFF, 8'h05);
    img[8'h0A] = 8'hFF;
    run_prog();
    chk("R4", "register selected by low bits", leds, 8'h37);

    // R8 R9: register, memory and immediate jump targets, jumps not taken
    for (int i = 0; i < 256; i++) img[i] = 8'hFF;
    put(8'h00, 8'h01, 8'h03, 8'h02, 8'h20);
    put(8'h04, 8'h08, 8'h00, 8'h02, 8'hFF);
    put(8'h20, 8'h01, 8'h06, 8'h90, 8'h30);
    put(8'h24, 8'h08, 8'h01, 8'h90, 8'hFF);
    put(8'h30, 8'h03, 8'h03, 8'h00, 8'h01);
    put(8'h34, 8'h09, 8'h03, 8'h50, 8'hFF);
    put(8'h37, 8'h0A, 8'h03, 8'h40, 8'hFF);
    put(8'h40, 8'h0D, 8'h03, 8'h00, 8'hFF);
    put(8'h44, 8'h09, 8'h03, 8'h48, 8'hFF);
    put(8'h48, 8'h01, 8'h02, 8'hFF, 8'h00);
    run_prog();
    chk("R9", "jump path ends at halt", pc, 8'h4C);
    chk("R6", "compare left R0 intact", leds, 8'hFF);

    // R5 R7 R10: memory-to-memory ALU, read-modify-write of LED byte
    for (int i = 0; i < 256; i++) img[i] = 8'hFF;
    img[8'h80] = 8'h0F; img[8'h81] = 8'hF1;
    put(8'h00, 8'h02, 8'h05, 8'h80, 8'h81);
    put(8'h04, 8'h0A, 8'h03, 8'h08, 8'hFF);
    put(8'h08, 8'h01, 8'h06, 8'hFF, 8'hA5);
    put(8'h0C, 8'h05, 8'h05, 8'hFF, 8'h81);
    run_prog();
    chk("R7", "OR into LED byte", leds, 8'hF5);
    chk("R3", "halt address", pc, 8'h10);

    // R5 R6 R7 R8: random straight-line programs with forward jumps
    for (int p = 0; p < 40; p++) begin
      gen_prog(16);
      run_prog();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule